// File: doc/BRIEF.md
# Four-Wide Register Rename Stage

This block renames a group of up to four instructions in one cycle. It sits between decode and scheduling. Each slot carries two source register numbers, one destination register number and flags that say whether the slot is live, whether it writes a register and whether each source is a register or an immediate. A map table holds, for every architectural register, either the physical tag of its newest producer or a marker meaning "value lives in the architectural file". Fresh destination tags come from an internal free-tag FIFO, which is refilled one tag per cycle through a return port.

The group is renamed as if its instructions were processed one after another. A source that an earlier slot of the same group writes takes that slot's new tag, and only the last writer of a register updates the table. Each destination also reports the mapping it displaces, so that later retirement logic can free it. A group may carry one branch, marked by its slot. The table state just after that slot is saved in a checkpoint. A misprediction restores the table from a checkpoint and releases that checkpoint and every younger one. A drain-recovery input points every entry back at the architectural file.

The map outputs and the accept flag are combinational from the inputs in the same cycle. The table, the checkpoints and the pool update on the rising clock edge, and only when the group is accepted.

Top module: `rn_rename`

## Requirements
- R1: After reset every register maps to the architectural file, and a register source then reads the 7-bit mapping value 0 (bit 6 = 0 means architectural file, bits 5:0 are the tag).
- R2: A register source that no earlier slot of its group writes returns the table mapping left by earlier accepted groups, encoded as bit 6 = 1 with the physical tag in bits 5:0.
- R3: A register source that one or more earlier live, writing slots of the same group target returns the new tag of the youngest such slot. Later slots are never forwarded.
- R4: When several slots of an accepted group write the same register, the table keeps the mapping of the last one.
- R5: A source flagged as an immediate returns the value 0 and takes no forwarding. Slots whose live flag is low neither forward nor consume tags.
- R6: Live writing slots take tags from the free FIFO in slot order. After reset the FIFO holds tags 0 to 63 in ascending order, and a returned tag joins its tail.
- R7: Each live writing slot outputs the mapping its destination held just before it, including a mapping created by an earlier slot of the same group.
- R8: A group whose writing slots outnumber the free tags is not accepted, and the table and the FIFO stay unchanged.
- R9: An accepted group with a branch saves a checkpoint of the table as it stands after all slots up to and including the branch slot. It reports the checkpoint's 2-bit id, and ids are handed out in ascending order modulo 4.
- R10: Recovery with an id loads the table from that checkpoint and frees that checkpoint and all younger ones, so the next branch reuses that id. No group is accepted in that cycle.
- R11: The drain-recovery input returns every entry to the architectural file and frees all checkpoints. No group is accepted in that cycle.
- R12: With all four checkpoints in use, a group carrying a branch is not accepted.
- R13: The release input frees the oldest checkpoint, which lets a branch group be accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_valid | input | 4 | Slot is live |
| grp_has_dst | input | 4 | Slot writes a register |
| src_a_is_reg | input | 4 | Source A is a register (0 = immediate) |
| src_b_is_reg | input | 4 | Source B is a register (0 = immediate) |
| src_a | input | 16 | Source A register per slot, 4 bits each |
| src_b | input | 16 | Source B register per slot, 4 bits each |
| dst_reg | input | 16 | Destination register per slot, 4 bits each |
| br_valid | input | 1 | Group holds a branch |
| br_slot | input | 2 | Slot of the branch |
| ckpt_release | input | 1 | Free the oldest checkpoint |
| recover | input | 1 | Restore the table from a checkpoint |
| recover_id | input | 2 | Checkpoint to restore |
| flush_to_arf | input | 1 | Point all entries at the architectural file |
| tag_ret_valid | input | 1 | A tag is returned to the pool |
| tag_ret | input | 6 | Returned tag |
| grp_accept | output | 1 | Group renamed this cycle |
| map_a | output | 28 | Source A mappings, 7 bits per slot |
| map_b | output | 28 | Source B mappings, 7 bits per slot |
| map_prev | output | 28 | Displaced destination mappings, 7 bits per slot |
| dst_tag | output | 24 | New destination tags, 6 bits per slot |
| br_ckpt_id | output | 2 | Checkpoint id for a branch in this group |

## Verification
The bench goes after chains in which a group reads a register that an earlier slot rewrote. A design that consulted only the table would hand out the stale architectural mapping there. It also drives four writers of one register, where a design that let the first writer win would leave a dead tag in the table. Further cases cover an immediate that names a register being rewritten, and a dead slot that carries a destination: a design that mishandled either would forward a tag or skip one in the allocation order. It also exhausts the tag pool and fills all checkpoints, then recovers to an older branch. A wrong stall or release rule there shows up as a group accepted without tags, a checkpoint id reused too early, or a table that keeps wrong-path mappings after recovery.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int TAG_W = 6;
  localparam int MAP_W = TAG_W + 1;

  // phys = 0: value held in the architectural file
  typedef struct packed {
    logic             phys;
    logic [TAG_W-1:0] tag;
  } rn_map_t;
endpackage

// File: rtl/rn_free_pool.sv
module rn_free_pool
  import rn_pkg::*;
#(
  parameter int W     = 4,
  parameter int NTAGS = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(W+1)-1:0]    pop_n,
  input  logic                      ret_valid,
  input  logic [TAG_W-1:0]          ret_tag,
  output logic [W-1:0][TAG_W-1:0]   avail,
  output logic [$clog2(NTAGS):0]    count
);
  localparam int PW = $clog2(NTAGS);

  logic [NTAGS-1:0][TAG_W-1:0] mem_q, mem_d;
  logic [PW-1:0]               rd_q, rd_d, wr_q, wr_d;
  logic [PW:0]                 cnt_q, cnt_d;

  always_comb begin
    mem_d = mem_q;
    if (ret_valid) mem_d[wr_q] = ret_tag;
    rd_d  = rd_q + PW'(pop_n);
    wr_d  = wr_q + PW'(ret_valid);
    cnt_d = cnt_q - (PW+1)'(pop_n) + (PW+1)'(ret_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAGS; i++) mem_q[i] <= TAG_W'(i);
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= (PW+1)'(NTAGS);
    end else begin
      mem_q <= mem_d;
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar k = 0; k < W; k++) begin : g_avail
    assign avail[k] = mem_q[rd_q + PW'(k)];
  end
  assign count = cnt_q;

  // R8
  pool_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pop_n) <= int'(cnt_q));
  // R6
  pool_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> (int'(cnt_q) + 1 <= NTAGS + int'(pop_n)));
endmodule

// File: rtl/rn_dep_check.sv
module rn_dep_check
  import rn_pkg::*;
#(
  parameter int W  = 4,
  parameter int AW = 4
) (
  input  logic [W-1:0]             writes,
  input  logic [W-1:0][AW-1:0]     dst,
  input  logic [W-1:0][AW-1:0]     sa,
  input  logic [W-1:0][AW-1:0]     sb,
  input  logic [W-1:0]             sa_reg,
  input  logic [W-1:0]             sb_reg,
  input  rn_map_t [W-1:0]          tbl_a,
  input  rn_map_t [W-1:0]          tbl_b,
  input  rn_map_t [W-1:0]          tbl_d,
  input  logic [W-1:0][TAG_W-1:0]  new_tag,
  output rn_map_t [W-1:0]          out_a,
  output rn_map_t [W-1:0]          out_b,
  output rn_map_t [W-1:0]          out_prev
);
  always_comb begin
    for (int i = 0; i < W; i++) begin
      out_a[i]    = tbl_a[i];
      out_b[i]    = tbl_b[i];
      out_prev[i] = tbl_d[i];
      // ascending scan: the youngest earlier writer wins
      for (int j = 0; j < W; j++) begin
        if (j < i && writes[j]) begin
          if (dst[j] == sa[i]) out_a[i]    = rn_map_t'({1'b1, new_tag[j]});
          if (dst[j] == sb[i]) out_b[i]    = rn_map_t'({1'b1, new_tag[j]});
          if (dst[j] == dst[i]) out_prev[i] = rn_map_t'({1'b1, new_tag[j]});
        end
      end
      if (!sa_reg[i]) out_a[i] = '0;
      if (!sb_reg[i]) out_b[i] = '0;
    end
  end
endmodule

// File: rtl/rn_rename.sv
module rn_rename
  import rn_pkg::*;
#(
  parameter int W     = 4,
  parameter int AREGS = 16,
  parameter int CKPTS = 4,
  parameter int NTAGS = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [W-1:0]                grp_valid,
  input  logic [W-1:0]                grp_has_dst,
  input  logic [W-1:0]                src_a_is_reg,
  input  logic [W-1:0]                src_b_is_reg,
  input  logic [W*$clog2(AREGS)-1:0]  src_a,
  input  logic [W*$clog2(AREGS)-1:0]  src_b,
  input  logic [W*$clog2(AREGS)-1:0]  dst_reg,
  input  logic                        br_valid,
  input  logic [$clog2(W)-1:0]        br_slot,
  input  logic                        ckpt_release,
  input  logic                        recover,
  input  logic [$clog2(CKPTS)-1:0]    recover_id,
  input  logic                        flush_to_arf,
  input  logic                        tag_ret_valid,
  input  logic [TAG_W-1:0]            tag_ret,
  output logic                        grp_accept,
  output logic [W*MAP_W-1:0]          map_a,
  output logic [W*MAP_W-1:0]          map_b,
  output logic [W*MAP_W-1:0]          map_prev,
  output logic [W*TAG_W-1:0]          dst_tag,
  output logic [$clog2(CKPTS)-1:0]    br_ckpt_id
);
  localparam int AW = $clog2(AREGS);
  localparam int CW = $clog2(CKPTS);
  localparam int NW = $clog2(W+1);
  localparam int PW = $clog2(NTAGS);

  logic [W-1:0][AW-1:0]    sa, sb, da;
  logic [W-1:0]            writes;
  logic [W-1:0][NW-1:0]    rank;
  logic [NW-1:0]           need;
  logic [W-1:0][TAG_W-1:0] avail, new_tag;
  logic [PW:0]             pool_cnt;
  rn_map_t [W-1:0]         tbl_a, tbl_b, tbl_d, o_a, o_b, o_prev;

  rn_map_t [AREGS-1:0]             tbl_q, tbl_n, snap;
  rn_map_t [CKPTS-1:0][AREGS-1:0]  ck_q, ck_n;
  logic [CW:0]                     head_q, head_n, tail_q, tail_n, ck_cnt;
  logic                            ck_full, stall;

  assign sa     = src_a;
  assign sb     = src_b;
  assign da     = dst_reg;
  assign writes = grp_valid & grp_has_dst;

  // allocation order and table reads
  always_comb begin
    need = '0;
    for (int i = 0; i < W; i++) begin
      rank[i]    = need;
      need       = need + NW'(writes[i]);
      new_tag[i] = avail[rank[i][$clog2(W)-1:0]];
      tbl_a[i]   = tbl_q[sa[i]];
      tbl_b[i]   = tbl_q[sb[i]];
      tbl_d[i]   = tbl_q[da[i]];
    end
  end

  assign ck_cnt  = tail_q - head_q;
  assign ck_full = (ck_cnt == (CW+1)'(CKPTS));
  assign stall   = (int'(pool_cnt) < int'(need)) || (br_valid && ck_full);
  assign grp_accept = (|grp_valid) && !stall && !flush_to_arf && !recover;

  rn_free_pool #(.W(W), .NTAGS(NTAGS)) u_pool (
    .clk       (clk),
    .rst_n     (rst_n),
    .pop_n     (grp_accept ? need : '0),
    .ret_valid (tag_ret_valid),
    .ret_tag   (tag_ret),
    .avail     (avail),
    .count     (pool_cnt)
  );

  rn_dep_check #(.W(W), .AW(AW)) u_dep (
    .writes   (writes),
    .dst      (da),
    .sa       (sa),
    .sb       (sb),
    .sa_reg   (src_a_is_reg),
    .sb_reg   (src_b_is_reg),
    .tbl_a    (tbl_a),
    .tbl_b    (tbl_b),
    .tbl_d    (tbl_d),
    .new_tag  (new_tag),
    .out_a    (o_a),
    .out_b    (o_b),
    .out_prev (o_prev)
  );

  // next table: later slots overwrite earlier ones, so the last writer stays
  always_comb begin
    tbl_n = tbl_q;
    snap  = tbl_q;
    for (int j = 0; j < W; j++) begin
      if (writes[j]) begin
        tbl_n[da[j]] = rn_map_t'({1'b1, new_tag[j]});
        if (j <= int'(br_slot)) snap[da[j]] = rn_map_t'({1'b1, new_tag[j]});
      end
    end
    if (flush_to_arf)     tbl_n = '0;
    else if (recover)     tbl_n = ck_q[recover_id];
    else if (!grp_accept) tbl_n = tbl_q;
  end

  // checkpoint queue
  always_comb begin
    ck_n   = ck_q;
    head_n = head_q;
    tail_n = tail_q;
    if (flush_to_arf) begin
      tail_n = head_q;
    end else if (recover) begin
      tail_n = head_q + {1'b0, CW'(recover_id - head_q[CW-1:0])};
    end else begin
      if (grp_accept && br_valid) begin
        ck_n[tail_q[CW-1:0]] = snap;
        tail_n = tail_q + 1'b1;
      end
      if (ckpt_release && ck_cnt != '0) head_n = head_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_q  <= '0;
      ck_q   <= '0;
      head_q <= '0;
      tail_q <= '0;
    end else begin
      tbl_q  <= tbl_n;
      ck_q   <= ck_n;
      head_q <= head_n;
      tail_q <= tail_n;
    end
  end

  assign map_a      = o_a;
  assign map_b      = o_b;
  assign map_prev   = o_prev;
  assign dst_tag    = new_tag;
  assign br_ckpt_id = tail_q[CW-1:0];

  // R11
  flush_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_to_arf |=> (tbl_q == '0));
  // R11
  flush_ckpt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_to_arf |=> (ck_cnt == '0));
  // R12
  ckpt_full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && ck_cnt == (CW+1)'(CKPTS)) |-> !grp_accept);
  // R8
  pool_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pool_cnt) < int'(need)) |-> !grp_accept);
  // R4
  last_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_accept && writes[W-1]) |=>
      (tbl_q[$past(da[W-1])] == rn_map_t'({1'b1, $past(new_tag[W-1])})));
endmodule

// File: tb/tb_rn_rename.sv
module tb_rn_rename;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  grp_valid, grp_has_dst, src_a_is_reg, src_b_is_reg;
  logic [15:0] src_a, src_b, dst_reg;
  logic        br_valid;
  logic [1:0]  br_slot;
  logic        ckpt_release, recover, flush_to_arf, tag_ret_valid;
  logic [1:0]  recover_id;
  logic [5:0]  tag_ret;
  logic        grp_accept;
  logic [27:0] map_a, map_b, map_prev;
  logic [23:0] dst_tag;
  logic [1:0]  br_ckpt_id;

  rn_rename dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  int mtbl[16];
  int mck[4][16];
  int ck_head = 0, ck_cnt = 0;
  int pool[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    grp_valid = '0; grp_has_dst = '0; src_a_is_reg = '0; src_b_is_reg = '0;
    src_a = '0; src_b = '0; dst_reg = '0; br_valid = 0; br_slot = '0;
    ckpt_release = 0; recover = 0; recover_id = '0; flush_to_arf = 0;
    tag_ret_valid = 0; tag_ret = '0;
  endtask

  task automatic slot(int i, bit v, bit hd, int d, int a, bit ar, int b, bit br);
    grp_valid[i] = v; grp_has_dst[i] = hd; dst_reg[i*4 +: 4] = 4'(d);
    src_a[i*4 +: 4] = 4'(a); src_a_is_reg[i] = ar;
    src_b[i*4 +: 4] = 4'(b); src_b_is_reg[i] = br;
  endtask

  // sequential reference rename of the driven group, checked, then clocked
  task automatic run_group(string req);
    int t[16]; int snapm[16]; int need = 0; int k = 0; bit stall;
    int ea, eb;
    for (int i = 0; i < 4; i++) if (grp_valid[i] && grp_has_dst[i]) need++;
    stall = (need > pool.size()) || (br_valid && ck_cnt == 4);
    t = mtbl; snapm = mtbl;
    #1;
    chk(grp_accept == !stall, req, "accept", grp_accept, !stall);
    if (!stall) begin
      for (int i = 0; i < 4; i++) begin
        if (grp_valid[i]) begin
          ea = src_a_is_reg[i] ? t[src_a[i*4 +: 4]] : 0;
          eb = src_b_is_reg[i] ? t[src_b[i*4 +: 4]] : 0;
          chk(int'(map_a[i*7 +: 7]) == ea, req, $sformatf("slot%0d src a", i), map_a[i*7 +: 7], ea);
          chk(int'(map_b[i*7 +: 7]) == eb, req, $sformatf("slot%0d src b", i), map_b[i*7 +: 7], eb);
          if (grp_has_dst[i]) begin
            chk(int'(map_prev[i*7 +: 7]) == t[dst_reg[i*4 +: 4]], req,
                $sformatf("slot%0d prev", i), map_prev[i*7 +: 7], t[dst_reg[i*4 +: 4]]);
            chk(int'(dst_tag[i*6 +: 6]) == pool[k], req,
                $sformatf("slot%0d tag", i), dst_tag[i*6 +: 6], pool[k]);
            t[dst_reg[i*4 +: 4]] = 64 + pool[k];
            k++;
          end
        end
        if (br_valid && i == int'(br_slot)) snapm = t;
      end
      if (br_valid)
        chk(int'(br_ckpt_id) == (ck_head + ck_cnt) % 4, req, "ckpt id",
            br_ckpt_id, (ck_head + ck_cnt) % 4);
    end
    @(posedge clk);
    if (!stall) begin
      mtbl = t;
      for (int i = 0; i < k; i++) void'(pool.pop_front());
      if (br_valid) begin
        mck[(ck_head + ck_cnt) % 4] = snapm;
        ck_cnt++;
      end
    end
    @(negedge clk);
    clear_in();
  endtask

  // reads every register through the sources of two groups
  task automatic probe(string req);
    for (int g = 0; g < 2; g++) begin
      for (int i = 0; i < 4; i++) slot(i, 1, 0, 0, g*8 + i*2, 1, g*8 + i*2 + 1, 1);
      run_group(req);
    end
  endtask

  task automatic do_recover(int id);
    recover = 1; recover_id = 2'(id);
    grp_valid = 4'b0001;
    #1;
    chk(grp_accept == 0, "R10", "accept during recovery", grp_accept, 0);
    @(posedge clk);
    mtbl = mck[id];
    ck_cnt = (id - ck_head + 4) % 4;
    @(negedge clk); clear_in();
  endtask

  task automatic do_flush();
    flush_to_arf = 1; grp_valid = 4'b0001;
    #1;
    chk(grp_accept == 0, "R11", "accept during flush", grp_accept, 0);
    @(posedge clk);
    for (int r = 0; r < 16; r++) mtbl[r] = 0;
    ck_cnt = 0;
    @(negedge clk); clear_in();
  endtask

  task automatic do_release();
    ckpt_release = 1;
    @(posedge clk);
    if (ck_cnt > 0) begin ck_head = (ck_head + 1) % 4; ck_cnt--; end
    @(negedge clk); clear_in();
  endtask

  task automatic do_return(int tg);
    tag_ret_valid = 1; tag_ret = 6'(tg);
    @(posedge clk);
    pool.push_back(tg);
    @(negedge clk); clear_in();
  endtask

  task automatic branch_only(string req);
    slot(0, 1, 0, 0, 1, 1, 2, 1);
    br_valid = 1; br_slot = 0;
    run_group(req);
  endtask

  // ---------------- scenarios ----------------
  task automatic test_reset();
    probe("R1");
  endtask

  task automatic test_chain();
    slot(0, 1, 1, 1, 2, 1, 3, 1);
    slot(1, 1, 1, 5, 4, 1, 1, 1);
    slot(2, 1, 1, 1, 1, 1, 5, 1);
    slot(3, 1, 1, 2, 5, 1, 1, 1);
    run_group("R3");
    probe("R2");
  endtask

  task automatic test_waw();
    slot(0, 1, 1, 1, 2, 1, 1, 1);
    slot(1, 1, 1, 2, 1, 1, 2, 1);
    slot(2, 1, 1, 1, 2, 1, 1, 1);
    slot(3, 1, 1, 1, 2, 1, 1, 1);
    run_group("R7");
    probe("R4");
  endtask

  task automatic test_imm();
    slot(0, 1, 1, 6, 0, 1, 0, 1);
    slot(1, 1, 0, 0, 6, 0, 6, 1);
    slot(2, 0, 1, 9, 6, 1, 6, 1);
    slot(3, 1, 1, 10, 9, 1, 6, 0);
    run_group("R5");
    slot(0, 1, 1, 11, 9, 1, 10, 1);
    run_group("R6");
  endtask

  task automatic test_branch();
    int first;
    first = (ck_head + ck_cnt) % 4;
    slot(0, 1, 1, 3, 1, 1, 2, 1);
    slot(1, 1, 0, 0, 3, 1, 0, 1);
    slot(2, 1, 1, 3, 3, 1, 4, 1);
    slot(3, 1, 1, 4, 3, 1, 2, 1);
    br_valid = 1; br_slot = 1;
    run_group("R9");
    slot(0, 1, 1, 3, 4, 1, 5, 1);
    slot(1, 1, 1, 5, 3, 1, 4, 1);
    slot(3, 1, 1, 6, 5, 1, 3, 1);
    br_valid = 1; br_slot = 3;
    run_group("R9");
    do_recover(first);
    probe("R10");
    branch_only("R10");
  endtask

  task automatic test_ckpt_full();
    while (ck_cnt < 4) branch_only("R9");
    branch_only("R12");
    probe("R12");
    do_release();
    branch_only("R13");
    do_recover((ck_head + 2) % 4);
    probe("R10");
  endtask

  task automatic test_flush();
    slot(0, 1, 1, 7, 7, 1, 8, 1);
    slot(1, 1, 1, 8, 7, 1, 8, 1);
    run_group("R11");
    do_flush();
    probe("R11");
    branch_only("R11");
  endtask

  task automatic test_pool();
    int r;
    while (pool.size() >= 4) begin
      for (int i = 0; i < 4; i++) slot(i, 1, 1, 8 + i, 8 + i, 1, 12 - i, 1);
      run_group("R6");
    end
    r = pool.size();
    for (int i = 0; i <= r; i++) slot(i, 1, 1, 12 + i, 12, 1, 1, 1);
    run_group("R8");
    probe("R8");
    for (int i = 0; i < r; i++) slot(i, 1, 1, 12 + i, 12, 1, 1, 1);
    run_group("R8");
    slot(0, 1, 1, 2, 1, 1, 2, 1);
    run_group("R8");
    slot(0, 1, 0, 0, 12, 1, 13, 1);
    run_group("R8");
    do_return(5);
    do_return(9);
    slot(0, 1, 1, 0, 1, 1, 2, 1);
    slot(1, 1, 1, 0, 0, 1, 2, 1);
    slot(2, 1, 1, 1, 0, 1, 1, 1);
    run_group("R8");
    slot(0, 1, 1, 0, 1, 1, 2, 1);
    slot(1, 1, 1, 3, 0, 1, 0, 1);
    run_group("R6");
    probe("R6");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    tests++; fails++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    clear_in();
    for (int i = 0; i < 64; i++) pool.push_back(i);
    for (int r = 0; r < 16; r++) mtbl[r] = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_chain();
    test_waw();
    test_imm();
    test_branch();
    test_ckpt_full();
    test_flush();
    test_pool();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule